// File: doc/BRIEF.md
# DMA Channel Enable Register Bank

This block holds the per-channel enable state of a 16-channel DMA controller: one request-enable vector and one error-interrupt-enable vector, each a bit per channel. The bits go straight to the channel logic on two output buses. Software reaches them through a byte-wide memory-mapped port. Each vector can be read, or loaded one byte at a time, at its own pair of offsets.

The main way to change an enable is a write-only command byte. Each vector has one set command and one clear command. A command byte acts on a single channel bit, or on every bit of the vector at once. This saves software a read-modify-write, so two agents can change different channels without racing each other. Command codes that name no existing channel are dropped without effect. The top bit of a command byte plays no part in decoding.

A write takes effect on the rising clock edge at which the write strobe is sampled high. The new vector shows on the outputs and through the read port from the next cycle. Reads are combinational on the address.

Top module: `dma_enable_bank`

## Requirements
- R1: After a synchronous reset both enable vectors are all zero.
- R2: A write of code 0 to 15 to the request-clear command at offset 0x19 clears only that channel's request-enable bit. The change is visible the cycle after the write edge.
- R3: A write to offset 0x19 with bit 6 of the data set (codes 64 to 127) clears all 16 request-enable bits.
- R4: At offset 0x1A, the error-interrupt set command, code 0 to 15 sets only that channel's error-interrupt-enable bit. Codes 64 to 127 set all 16 bits.
- R5: Two companion commands use the same code rules with the opposite action. Offset 0x18 sets request-enable bits, and offset 0x1B clears error-interrupt-enable bits.
- R6: Codes 16 to 63 (bit 6 clear and bits 5:4 not both zero) written to any command offset leave both vectors unchanged.
- R7: Bit 7 of a command byte is ignored: data 0x80|c acts exactly as c.
- R8: Reads of the four command offsets 0x18 to 0x1B always return zero.
- R9: The request vector reads at 0x0E (channels 15 to 8, channel 8 in bit 0) and 0x0F (channels 7 to 0). The error-interrupt vector reads at 0x16 and 0x17 with the same layout. A write to one of these offsets loads that byte.
- R10: Reads of any other offset return zero, and writes to them change neither vector.
- R11: The outputs req_enable and err_irq_enable always equal the stored vectors, with bit n for channel n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the byte port |
| addr | input | 8 | Byte offset for reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte for the current offset (combinational) |
| req_enable | output | 16 | Request-enable bit per channel |
| err_irq_enable | output | 16 | Error-interrupt-enable bit per channel |

## Verification
Command bytes are sent for the lowest and highest channel numbers and for middle channels. This shows whether the channel field is decoded at its true width rather than shifted or truncated. Codes 0x10, 0x20 and 0x3F probe the reserved band from both ends, so a decoder that looks only at the low nibble is caught. Codes 0x40, 0x7F and 0xC0 show that bit 6 alone selects the global action. Commands with bit 7 set, when compared against the same codes without it, expose any use of that bit. Byte loads with asymmetric patterns tell the high and low bytes of each vector apart.

// File: rtl/dma_enable_pkg.sv
package dma_enable_pkg;

    // Bit position of the "every channel" flag inside a command byte
    localparam int CMD_ALL_BIT = 6;

    // Vector identifiers
    localparam int VEC_REQ = 0;
    localparam int VEC_ERR = 1;
    localparam int NUM_VEC = 2;

    // Decoded view of the low seven bits of a command byte
    typedef struct packed {
        logic       all;   // bit 6: act on every channel
        logic [5:0] code;  // bits 5:0: channel number
    } cmd_code_t;

    function automatic cmd_code_t to_cmd(input logic [6:0] raw);
        cmd_code_t c;
        c.all  = raw[CMD_ALL_BIT];
        c.code = raw[5:0];
        return c;
    endfunction

    // Set command offset: request 0x18, error interrupt 0x1A
    function automatic int set_cmd_addr(input int v);
        return 8'h18 + 2 * v;
    endfunction

    // Clear command offset: request 0x19, error interrupt 0x1B
    function automatic int clr_cmd_addr(input int v);
        return 8'h19 + 2 * v;
    endfunction

    // Offset of byte k (counted from the most significant byte) of vector v
    function automatic int vec_byte_addr(input int v, input int k);
        return ((v == VEC_REQ) ? 8'h0E : 8'h16) + k;
    endfunction

endpackage

// File: rtl/dma_enable_cmd_decode.sv
module dma_enable_cmd_decode
    import dma_enable_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic           valid,
    input  logic [6:0]     cmd_raw,
    output logic [NCH-1:0] mask
);

    cmd_code_t cmd;
    assign cmd = to_cmd(cmd_raw);

    // One decode term per channel; codes beyond NCH-1 select nothing
    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign mask[i] = valid & (cmd.all | (cmd.code == 6'(i)));
    end

    always_comb begin
        if (valid && cmd.all) begin
            assert_all_code_R3 : assert (&mask);
        end
        if (valid && !cmd.all) begin
            assert_single_or_none_R6 : assert ($countones(mask) <= 1);
        end
        if (!valid) begin
            assert_idle_no_mask_R10 : assert (mask == '0);
        end
    end

endmodule

// File: rtl/dma_enable_vector.sv
module dma_enable_vector #(
    parameter int NCH = 16,
    localparam int NB = NCH / 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_mask,
    input  logic [NCH-1:0] clr_mask,
    input  logic [NB-1:0]  load_en,
    input  logic [7:0]     load_byte,
    output logic [NCH-1:0] q
);

    logic [NCH-1:0] q_next;

    always_comb begin
        q_next = q;
        for (int b = 0; b < NB; b++) begin
            if (load_en[b]) q_next[b*8 +: 8] = load_byte;
        end
        q_next = (q_next | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    // Channels outside the command mask keep their state
    assert_bits_kept_R6 : assert property (@(posedge clk) disable iff (rst)
        (load_en == '0) |=>
        (((q ^ $past(q)) & ~($past(set_mask) | $past(clr_mask))) == '0));

    // Clearing leaves the selected channels at zero
    assert_clear_hit_R2 : assert property (@(posedge clk) disable iff (rst)
        ((clr_mask != '0) && (load_en == '0) && (set_mask == '0)) |=>
        ((q & $past(clr_mask)) == '0));

    // Setting leaves the selected channels at one
    assert_set_hit_R4 : assert property (@(posedge clk) disable iff (rst)
        ((set_mask != '0) && (load_en == '0) && (clr_mask == '0)) |=>
        ((q & $past(set_mask)) == $past(set_mask)));

endmodule

// File: rtl/dma_enable_bank.sv
module dma_enable_bank
    import dma_enable_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [NCH-1:0]    req_enable,
    output logic [NCH-1:0]    err_irq_enable
);

    localparam int NB = NCH / 8;

    logic [NUM_VEC-1:0][NCH-1:0] vec_q;
    logic [NUM_VEC-1:0]          vec_hit;
    logic [NUM_VEC-1:0]          cmd_hit;
    logic [NUM_VEC-1:0][7:0]     vec_rd;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic           set_sel, clr_sel;
        logic [NB-1:0]  load_sel;
        logic [NB-1:0]  rd_sel;
        logic [NCH-1:0] set_mask, clr_mask;

        assign set_sel = wr_en && (addr == ADDR_W'(set_cmd_addr(v)));
        assign clr_sel = wr_en && (addr == ADDR_W'(clr_cmd_addr(v)));

        // Byte b of the vector sits at base + (NB-1-b): high byte first
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign rd_sel[b]   = (addr == ADDR_W'(vec_byte_addr(v, NB - 1 - b)));
            assign load_sel[b] = wr_en && rd_sel[b];
        end

        dma_enable_cmd_decode #(.NCH(NCH)) u_set_dec (
            .valid   (set_sel),
            .cmd_raw (wr_data[6:0]),
            .mask    (set_mask)
        );

        dma_enable_cmd_decode #(.NCH(NCH)) u_clr_dec (
            .valid   (clr_sel),
            .cmd_raw (wr_data[6:0]),
            .mask    (clr_mask)
        );

        dma_enable_vector #(.NCH(NCH)) u_vec (
            .clk       (clk),
            .rst       (rst),
            .set_mask  (set_mask),
            .clr_mask  (clr_mask),
            .load_en   (load_sel),
            .load_byte (wr_data),
            .q         (vec_q[v])
        );

        assign cmd_hit[v] = (addr == ADDR_W'(set_cmd_addr(v))) ||
                            (addr == ADDR_W'(clr_cmd_addr(v)));
        assign vec_hit[v] = cmd_hit[v] || (rd_sel != '0);

        always_comb begin
            vec_rd[v] = '0;
            for (int b = 0; b < NB; b++) begin
                if (rd_sel[b]) vec_rd[v] = vec_q[v][b*8 +: 8];
            end
        end
    end

    // Command offsets contribute nothing, so they read as zero
    always_comb begin
        rd_data = '0;
        for (int v = 0; v < NUM_VEC; v++) rd_data |= vec_rd[v];
    end

    assign req_enable     = vec_q[VEC_REQ];
    assign err_irq_enable = vec_q[VEC_ERR];

    assert_cmd_reads_zero_R8 : assert property (@(posedge clk) disable iff (rst)
        (cmd_hit != '0) |-> (rd_data == 8'h00));

    assert_unmapped_write_R10 : assert property (@(posedge clk) disable iff (rst)
        (wr_en && (vec_hit == '0)) |=> ($stable(req_enable) && $stable(err_irq_enable)));

    assert_unmapped_read_R10 : assert property (@(posedge clk) disable iff (rst)
        (vec_hit == '0) |-> (rd_data == 8'h00));

endmodule

// File: tb/dma_enable_bank_test.sv
module dma_enable_bank_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;
    logic [15:0] req_enable;
    logic [15:0] err_irq_enable;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dma_enable_bank #(.NCH(16), .ADDR_W(8)) uut (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .addr           (addr),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .req_enable     (req_enable),
        .err_irq_enable (err_irq_enable)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  d;
        logic [15:0] exp_req;
        logic [15:0] exp_err;
        logic [3:0]  tag;
    } step_t;

    // Sequential steps from reset; tag = requirement number
    localparam int NSTEP = 20;
    localparam step_t STEPS [NSTEP] = '{
        '{8'h18, 8'h40, 16'hFFFF, 16'h0000, 4'd5},  // R5 set all requests
        '{8'h19, 8'h03, 16'hFFF7, 16'h0000, 4'd2},  // R2 clear channel 3
        '{8'h19, 8'h0F, 16'h7FF7, 16'h0000, 4'd2},  // R2 clear channel 15
        '{8'h19, 8'h00, 16'h7FF6, 16'h0000, 4'd2},  // R2 clear channel 0
        '{8'h19, 8'h10, 16'h7FF6, 16'h0000, 4'd6},  // R6 reserved low end
        '{8'h19, 8'h3F, 16'h7FF6, 16'h0000, 4'd6},  // R6 reserved high end
        '{8'h1A, 8'h05, 16'h7FF6, 16'h0020, 4'd4},  // R4 set err channel 5
        '{8'h1A, 8'h8C, 16'h7FF6, 16'h1020, 4'd7},  // R7 bit 7 ignored
        '{8'h1A, 8'h20, 16'h7FF6, 16'h1020, 4'd6},  // R6 reserved
        '{8'h1B, 8'h05, 16'h7FF6, 16'h1000, 4'd5},  // R5 clear err channel 5
        '{8'h1A, 8'h7F, 16'h7FF6, 16'hFFFF, 4'd4},  // R4 set all err
        '{8'h19, 8'hC0, 16'h0000, 16'hFFFF, 4'd3},  // R3 clear all requests
        '{8'h18, 8'h09, 16'h0200, 16'hFFFF, 4'd5},  // R5 set request channel 9
        '{8'h1B, 8'h41, 16'h0200, 16'h0000, 4'd5},  // R5 clear all err
        '{8'h0F, 8'hA5, 16'h02A5, 16'h0000, 4'd9},  // R9 load request low byte
        '{8'h0E, 8'h3C, 16'h3CA5, 16'h0000, 4'd9},  // R9 load request high byte
        '{8'h17, 8'h81, 16'h3CA5, 16'h0081, 4'd9},  // R9 load err low byte
        '{8'h16, 8'h7E, 16'h3CA5, 16'h7E81, 4'd9},  // R9 load err high byte
        '{8'h05, 8'hFF, 16'h3CA5, 16'h7E81, 4'd10}, // R10 unmapped write
        '{8'h1C, 8'hFF, 16'h3CA5, 16'h7E81, 4'd10}  // R10 unmapped write
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wr_data = 8'h00;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, {8'h00, rd_data}, {8'h00, exp});
    endtask

    task automatic check_vectors(input string req, input logic [15:0] er, input logic [15:0] ee);
        check({req, " req_enable"}, req_enable, er);
        check({req, " err_irq_enable"}, err_irq_enable, ee);
        read_check({req, " rd 0x0E"}, 8'h0E, er[15:8]);
        read_check({req, " rd 0x0F"}, 8'h0F, er[7:0]);
        read_check({req, " rd 0x16"}, 8'h16, ee[15:8]);
        read_check({req, " rd 0x17"}, 8'h17, ee[7:0]);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = 8'h00; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R11 outputs mirror vectors
        check_vectors("R1", 16'h0000, 16'h0000);

        // Table walk: R2 R3 R4 R5 R6 R7 R9 R10 R11
        for (int i = 0; i < NSTEP; i++) begin
            write_byte(STEPS[i].a, STEPS[i].d);
            check_vectors($sformatf("R%0d step %0d", STEPS[i].tag, i),
                          STEPS[i].exp_req, STEPS[i].exp_err);
        end

        // R8 command offsets read zero while vectors are non-zero
        for (int a = 8'h18; a <= 8'h1B; a++) begin
            read_check("R8 command read", 8'(a), 8'h00);
        end

        // R10 unmapped reads return zero
        read_check("R10 unmapped 0x00", 8'h00, 8'h00);
        read_check("R10 unmapped 0x10", 8'h10, 8'h00);
        read_check("R10 unmapped 0x1C", 8'h1C, 8'h00);
        read_check("R10 unmapped 0xFF", 8'hFF, 8'h00);

        // R7 bit 7 on a global code: 0xC0 to set err clears nothing, sets all
        write_byte(8'h1A, 8'hC0);
        check_vectors("R7 global with bit 7", 16'h3CA5, 16'hFFFF);

        // R2 single clear visible exactly one cycle after the edge
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h19; wr_data = 8'h05;
        #1;
        check("R2 before edge", req_enable, 16'h3CA5);
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 after edge", req_enable, 16'h3C85);

        // R1 reset from a non-zero state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_vectors("R1 re-reset", 16'h0000, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule